// File: doc/BRIEF.md
# Charger-Detector Two-Wire Register Target with Interrupt Latch

This block is the control-side interface of a battery-charger detector. A host reaches it over an I2C bus, at 7-bit address 0x2C. The block holds a small register file: an identity byte, three configuration bytes, and a status byte made of live detector flags. It also latches three interrupt events and drives one interrupt pin. The pin's polarity is programmable, and a master enable masks the pin without discarding events.

SCL and SDA are sampled by the system clock through a two-flop synchronizer. START, STOP and bus edges are derived from the sampled values. SDA is modelled as an open-drain enable: `sda_oe` high means the line is pulled low. A byte pointer survives from one transaction to the next. The first byte written after the address loads the pointer. Each later byte, written or read, uses the pointer and then advances it by one.

The protocol engine is a state machine with these states:
- IDLE waits for START.
- ADDR shifts in the address byte. On a match it moves to ADDR_ACK; otherwise it returns to IDLE.
- ADDR_ACK goes to RDATA for a read or to PTR for a write.
- PTR receives the pointer byte and goes to PTR_ACK, which leads to WDATA.
- WDATA stores a byte and goes to WDATA_ACK, which returns to WDATA.
- RDATA shifts out a byte and goes to RACK.
- RACK returns to RDATA when the master acknowledges, or to IDLE when it does not.
- From any state, START leads to ADDR and STOP leads to IDLE.

Top module: `chgdet_i2c_target`

## Requirements
- R1: The block acknowledges address byte 0x58 (write) and 0x59 (read). Any other address byte gets no acknowledge, and the bus is ignored until the next START.
- R2: The first byte after a write address loads the pointer. If STOP follows that byte, no register changes.
- R3: Each further write byte goes to the register at the pointer, and the pointer then increments by one, wrapping from 0xFF to 0x00.
- R4: A read begins at the stored pointer, which persists across transactions. Each byte read advances the pointer. After the master answers a byte with NACK, the block releases SDA and drives nothing more.
- R5: Address 0x00 reads 0x21 and ignores writes. Addresses 0x05 to 0xFF read 0x00. Writes to them are acknowledged and have no effect.
- R6: After reset, cfg_a (0x01) is 0x09 and cfg_b (0x03) and cfg_c (0x04) are 0x00, so the interrupt pin is high. In cfg_a, bit 7 is polarity, bit 6 is interrupt enable, bit 3 is low-power and bit 0 is detect-enable.
- R7: Address 0x02 reads {st_kind[2:0], st_vbus, st_deadbat, st_dcd, st_busy, 1'b0}, from bit 7 down to bit 0, and ignores writes.
- R8: A pending event latches on any change of st_vbus and on a 0-to-1 transition of st_deadbat or st_dcd. A 1-to-0 transition of st_deadbat or st_dcd latches nothing.
- R9: Reading address 0x02 clears every pending event. The clear takes effect when the byte is loaded for transmission.
- R10: The interrupt is active when the enable bit is 1 and an event is pending. With polarity 0 the pin is low when active and high otherwise; with polarity 1 the levels are inverted. Clearing the enable bit releases the pin but keeps events latched.
- R11: A START at any point, including mid-byte, restarts the address phase. A STOP returns the block to IDLE.
- R12: The acknowledge is driven from the SCL fall after bit 8 until the next SCL fall. SDA is changed only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | High pulls SDA low |
| st_kind | input | 3 | Detected charger type code |
| st_vbus | input | 1 | Bus-power comparator result |
| st_deadbat | input | 1 | Dead-battery charge mode active |
| st_dcd | input | 1 | Data-contact wait timed out |
| st_busy | input | 1 | Detection sequence running |
| cfg_a | output | 8 | Configuration register 0x01 |
| cfg_b | output | 8 | Configuration register 0x03 |
| cfg_c | output | 8 | Configuration register 0x04 |
| irq_pin | output | 1 | Interrupt pin level |

## Verification
The hardest situation to reach is the interplay of latched events, masking and clear-on-read. An event must survive a masked period and reappear on the pin when the mask is lifted. A status read must wipe events that arrived before it.

The stimulus reaches this by sweeping all eight combinations of polarity, enable and pending. It also toggles each status source in both directions between status reads. Every status read is made through a pointer write followed by a repeated START, so the clear is triggered only through the real bus path. Pointer wrap-around and a START inside a half-sent byte are forced with explicit bus sequences.

// File: rtl/chgdet_i2c_pkg.sv
package chgdet_i2c_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_PTR,
        S_PTR_ACK,
        S_WDATA,
        S_WDATA_ACK,
        S_RDATA,
        S_RACK
    } link_st_t;

    localparam logic [7:0] REG_ID    = 8'h00;
    localparam logic [7:0] REG_CFG_A = 8'h01;
    localparam logic [7:0] REG_STAT  = 8'h02;
    localparam logic [7:0] REG_CFG_B = 8'h03;
    localparam logic [7:0] REG_CFG_C = 8'h04;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_link_fsm.sv
module i2c_link_fsm
    import chgdet_i2c_pkg::*;
#(
    parameter logic [6:0] ADDR7 = 7'h2C
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_s,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [7:0] rd_data,
    output logic [7:0] ptr,
    output logic       wr_en,
    output logic [7:0] wr_data,
    output logic       rd_stb,
    output logic       sda_oe
);

    link_st_t   state, nxt;
    logic [7:0] sh;
    logic [7:0] tx;
    logic [3:0] cnt;
    logic       rw;
    logic       mack;
    logic       byte_done;
    logic       rx_state;

    assign byte_done = scl_fall && (cnt == 4'd8);
    assign rx_state  = (state == S_ADDR) || (state == S_PTR) || (state == S_WDATA);

    always_comb begin
        nxt = state;
        if (start_det) begin
            nxt = S_ADDR;
        end else if (stop_det) begin
            nxt = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE:      nxt = S_IDLE;
                S_ADDR:      if (byte_done) nxt = (sh[7:1] == ADDR7) ? S_ADDR_ACK : S_IDLE;
                S_ADDR_ACK:  if (scl_fall) nxt = rw ? S_RDATA : S_PTR;
                S_PTR:       if (byte_done) nxt = S_PTR_ACK;
                S_PTR_ACK:   if (scl_fall) nxt = S_WDATA;
                S_WDATA:     if (byte_done) nxt = S_WDATA_ACK;
                S_WDATA_ACK: if (scl_fall) nxt = S_WDATA;
                S_RDATA:     if (scl_fall && cnt == 4'd7) nxt = S_RACK;
                S_RACK:      if (scl_fall) nxt = mack ? S_RDATA : S_IDLE;
                default:     nxt = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh   <= '0;
            tx   <= '0;
            cnt  <= '0;
            ptr  <= '0;
            rw   <= 1'b0;
            mack <= 1'b0;
        end else begin
            if (start_det) begin
                cnt <= '0;
            end else if (scl_rise && rx_state) begin
                sh  <= {sh[6:0], sda_s};
                cnt <= cnt + 4'd1;
            end else if (byte_done && rx_state) begin
                cnt <= '0;
            end
            if (scl_rise && state == S_RACK) mack <= ~sda_s;
            if (byte_done && state == S_ADDR) rw <= sh[0];
            if (byte_done && state == S_PTR) ptr <= sh;
            if (wr_en) ptr <= ptr + 8'd1;
            if (rd_stb) begin
                tx  <= rd_data;
                ptr <= ptr + 8'd1;
                cnt <= '0;
            end else if (scl_fall && state == S_RDATA) begin
                tx  <= {tx[6:0], 1'b0};
                cnt <= (cnt == 4'd7) ? 4'd0 : cnt + 4'd1;
            end
        end
    end

    always_comb begin
        sda_oe = 1'b0;
        unique case (state)
            S_ADDR_ACK, S_PTR_ACK, S_WDATA_ACK: sda_oe = 1'b1;
            S_RDATA:                            sda_oe = ~tx[7];
            default:                            sda_oe = 1'b0;
        endcase
    end

    assign wr_en   = (state == S_WDATA) && byte_done;
    assign wr_data = sh;
    assign rd_stb  = scl_fall && (((state == S_ADDR_ACK) && rw) || ((state == S_RACK) && mack));

    assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ptr == $past(ptr) + 8'd1));

    assert_oe_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    assert_stop_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> (state == S_IDLE));

endmodule

// File: rtl/chgdet_regfile.sv
module chgdet_regfile
    import chgdet_i2c_pkg::*;
#(
    parameter logic [7:0] ID_VALUE  = 8'h21,
    parameter logic [7:0] CFG_A_RST = 8'h09,
    parameter logic [7:0] CFG_B_RST = 8'h00,
    parameter logic [7:0] CFG_C_RST = 8'h00,
    parameter int         NSRC      = 3,
    parameter logic [NSRC-1:0] EDGE_ANY = 3'b001
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [7:0] rd_addr,
    input  logic       rd_stb,
    output logic [7:0] rd_data,
    input  logic [2:0] st_kind,
    input  logic       st_vbus,
    input  logic       st_deadbat,
    input  logic       st_dcd,
    input  logic       st_busy,
    output logic [7:0] cfg_a,
    output logic [7:0] cfg_b,
    output logic [7:0] cfg_c,
    output logic       irq_pin
);

    logic [NSRC-1:0] src, prev, hit, pend;
    logic            clr;
    logic            irq_act;
    logic [7:0]      stat;

    assign src  = {st_dcd, st_deadbat, st_vbus};
    assign stat = {st_kind, st_vbus, st_deadbat, st_dcd, st_busy, 1'b0};
    assign clr  = rd_stb && (rd_addr == REG_STAT);

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        if (EDGE_ANY[i]) begin : g_any
            assign hit[i] = src[i] ^ prev[i];
        end else begin : g_rise
            assign hit[i] = src[i] & ~prev[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev  <= '0;
            pend  <= '0;
            cfg_a <= CFG_A_RST;
            cfg_b <= CFG_B_RST;
            cfg_c <= CFG_C_RST;
        end else begin
            prev <= src;
            pend <= hit | (pend & {NSRC{~clr}});
            if (wr_en) begin
                case (wr_addr)
                    REG_CFG_A: cfg_a <= wr_data;
                    REG_CFG_B: cfg_b <= wr_data;
                    REG_CFG_C: cfg_c <= wr_data;
                    default:   ;
                endcase
            end
        end
    end

    always_comb begin
        case (rd_addr)
            REG_ID:    rd_data = ID_VALUE;
            REG_CFG_A: rd_data = cfg_a;
            REG_STAT:  rd_data = stat;
            REG_CFG_B: rd_data = cfg_b;
            REG_CFG_C: rd_data = cfg_c;
            default:   rd_data = 8'h00;
        endcase
    end

    assign irq_act = cfg_a[6] & (|pend);
    assign irq_pin = cfg_a[7] ? irq_act : ~irq_act;

    assert_clear_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && hit == '0) |=> (pend == '0));

    assert_rise_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_deadbat) |=> pend[1]);

    assert_ro_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == REG_ID || wr_addr == REG_STAT || wr_addr > REG_CFG_C))
        |=> ($stable(cfg_a) && $stable(cfg_b) && $stable(cfg_c)));

    assert_mask_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_a[6] && (|pend) && !clr) |=> (|pend));

endmodule

// File: rtl/chgdet_i2c_target.sv
module chgdet_i2c_target #(
    parameter logic [6:0] ADDR7       = 7'h2C,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_oe,
    input  logic [2:0] st_kind,
    input  logic       st_vbus,
    input  logic       st_deadbat,
    input  logic       st_dcd,
    input  logic       st_busy,
    output logic [7:0] cfg_a,
    output logic [7:0] cfg_b,
    output logic [7:0] cfg_c,
    output logic       irq_pin
);

    logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [7:0] ptr, wr_data, rd_data;
    logic       wr_en, rd_stb;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_link_fsm #(.ADDR7(ADDR7)) u_link (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
        .stop_det(stop_det), .rd_data(rd_data), .ptr(ptr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_stb(rd_stb), .sda_oe(sda_oe)
    );

    chgdet_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(ptr), .wr_data(wr_data),
        .rd_addr(ptr), .rd_stb(rd_stb), .rd_data(rd_data),
        .st_kind(st_kind), .st_vbus(st_vbus), .st_deadbat(st_deadbat),
        .st_dcd(st_dcd), .st_busy(st_busy),
        .cfg_a(cfg_a), .cfg_b(cfg_b), .cfg_c(cfg_c), .irq_pin(irq_pin)
    );

endmodule

// File: tb/sim_chgdet_i2c_target.sv
`timescale 1ns/100ps
module sim_chgdet_i2c_target;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       scl, sda_m;
    logic       sda_oe, sda_bus;
    logic [2:0] st_kind;
    logic       st_vbus, st_deadbat, st_dcd, st_busy;
    logic [7:0] cfg_a, cfg_b, cfg_c;
    logic       irq_pin;
    int         checks = 0;
    int         fails = 0;
    logic       done = 1'b0;

    always #2.5 clk = ~clk;
    assign sda_bus = sda_m & ~sda_oe;

    chgdet_i2c_target u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus), .sda_oe(sda_oe),
        .st_kind(st_kind), .st_vbus(st_vbus), .st_deadbat(st_deadbat),
        .st_dcd(st_dcd), .st_busy(st_busy),
        .cfg_a(cfg_a), .cfg_b(cfg_b), .cfg_c(cfg_c), .irq_pin(irq_pin)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hp();
        repeat (10) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hp(); scl = 1'b1; hp(); sda_m = 1'b0; hp(); scl = 1'b0; hp();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hp(); scl = 1'b1; hp(); sda_m = 1'b1; hp();
    endtask

    task automatic bitx(input logic b, output logic r);
        sda_m = b; hp(); scl = 1'b1; hp(); r = sda_bus; scl = 1'b0; hp();
    endtask

    task automatic wbyte(input logic [7:0] b, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) bitx(b[i], r);
        bitx(1'b1, r);
        ack = ~r;
    endtask

    task automatic rbyte(input logic mack, output logic [7:0] b);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            bitx(1'b1, r);
            b[i] = r;
        end
        bitx(~mack, r);
    endtask

    task automatic wr1(input logic [7:0] p, input logic [7:0] d);
        logic a;
        bus_start();
        wbyte(8'h58, a); chk("R1 write address ack", {7'd0, a}, 8'd1);
        wbyte(p, a);
        wbyte(d, a);     chk("R1 data ack", {7'd0, a}, 8'd1);
        bus_stop();
    endtask

    task automatic set_ptr(input logic [7:0] p);
        logic a;
        bus_start(); wbyte(8'h58, a); wbyte(p, a); bus_stop();
    endtask

    task automatic rd_at(input logic [7:0] p, output logic [7:0] b);
        logic a;
        bus_start(); wbyte(8'h58, a); wbyte(p, a);
        bus_start(); wbyte(8'h59, a);
        chk("R1 read address ack", {7'd0, a}, 8'd1);
        rbyte(1'b0, b);
        bus_stop();
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        logic [7:0] b;
        logic       a;
        logic [7:0] exp_mem [8];
        scl = 1'b1; sda_m = 1'b1; rst_n = 1'b0;
        st_kind = 3'd0; st_vbus = 1'b0; st_deadbat = 1'b0; st_dcd = 1'b0; st_busy = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        settle();

        // reset state
        chk("R6 irq pin after reset", {7'd0, irq_pin}, 8'd1);
        chk("R12 sda released after reset", {7'd0, sda_oe}, 8'd0);
        rd_at(8'h01, b); chk("R6 cfg_a reset", b, 8'h09);
        rd_at(8'h03, b); chk("R6 cfg_b reset", b, 8'h00);
        rd_at(8'h04, b); chk("R6 cfg_c reset", b, 8'h00);

        // identity and unmapped space
        rd_at(8'h00, b); chk("R5 id value", b, 8'h21);
        wr1(8'h00, 8'h55);
        rd_at(8'h00, b); chk("R5 id ignores write", b, 8'h21);
        wr1(8'h06, 8'h77);
        rd_at(8'h06, b); chk("R5 unmapped reads zero", b, 8'h00);

        // pointer-only write
        wr1(8'h03, 8'h5A);
        set_ptr(8'h04);
        chk("R2 pointer write keeps cfg_b", cfg_b, 8'h5A);
        chk("R2 pointer write keeps cfg_c", cfg_c, 8'h00);
        bus_start(); wbyte(8'h59, a); rbyte(1'b0, b); bus_stop();
        chk("R2 read from stored pointer", b, 8'h00);

        // sweep of all low addresses, then one burst read
        st_kind = 3'd5; st_busy = 1'b1;
        for (int k = 0; k < 8; k++) wr1(8'(k), 8'h3C + 8'(k) * 8'h11);
        for (int k = 0; k < 8; k++) exp_mem[k] = 8'h00;
        exp_mem[0] = 8'h21;
        exp_mem[1] = 8'h3C + 8'h11;
        exp_mem[2] = {3'd5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
        exp_mem[3] = 8'h3C + 8'h33;
        exp_mem[4] = 8'h3C + 8'h44;
        bus_start(); wbyte(8'h58, a); wbyte(8'h00, a);
        bus_start(); wbyte(8'h59, a);
        for (int k = 0; k < 8; k++) begin
            rbyte(k != 7, b);
            chk("R4 burst read (R7 status at 2)", b, exp_mem[k]);
        end
        rbyte(1'b1, b);
        chk("R4 no drive after nack", b, 8'hFF);
        bus_stop();
        bus_start(); wbyte(8'h59, a); rbyte(1'b0, b); bus_stop();
        chk("R4 pointer persisted past 7", b, 8'h00);
        wr1(8'h02, 8'hFF);
        rd_at(8'h02, b); chk("R7 status ignores write", b, 8'hA2);

        // multi-byte write with increment
        bus_start(); wbyte(8'h58, a); wbyte(8'h03, a);
        wbyte(8'hA1, a); wbyte(8'hB2, a); wbyte(8'hC3, a);
        chk("R5 unmapped write acked", {7'd0, a}, 8'd1);
        bus_stop();
        chk("R3 burst write cfg_b", cfg_b, 8'hA1);
        chk("R3 burst write cfg_c", cfg_c, 8'hB2);

        // pointer wrap
        bus_start(); wbyte(8'h58, a); wbyte(8'hFF, a);
        wbyte(8'h11, a); wbyte(8'h22, a); wbyte(8'h33, a); bus_stop();
        chk("R3 pointer wrap to cfg_a", cfg_a, 8'h33);

        // foreign address
        bus_start(); wbyte(8'h5A, a);
        chk("R1 foreign address nack", {7'd0, a}, 8'd0);
        wbyte(8'h01, a); wbyte(8'h00, a); bus_stop();
        chk("R1 foreign write ignored", cfg_a, 8'h33);
        bus_start(); wbyte(8'h5B, a); bus_stop();
        chk("R1 foreign read nack", {7'd0, a}, 8'd0);

        // START inside a byte, then repeated START read after write
        bus_start(); bitx(1'b1, a); bitx(1'b0, a); bitx(1'b1, a); bitx(1'b1, a);
        bus_start(); wbyte(8'h58, a); wbyte(8'h04, a); wbyte(8'h6E, a); bus_stop();
        chk("R11 restart mid-byte", cfg_c, 8'h6E);
        bus_start(); wbyte(8'h58, a); wbyte(8'h03, a); wbyte(8'h44, a);
        bus_start(); wbyte(8'h59, a); rbyte(1'b0, b); bus_stop();
        chk("R11 repeated start read", b, 8'h6E);
        chk("R12 ack seen on data (cfg_b written)", cfg_b, 8'h44);

        // interrupt sweep: polarity x enable x pending
        for (int k = 0; k < 8; k++) begin
            logic pol, en, pd, act;
            pol = k[2]; en = k[1]; pd = k[0];
            wr1(8'h01, {pol, en, 6'b001001});
            rd_at(8'h02, b);
            if (pd) begin
                st_vbus = ~st_vbus;
                settle();
            end
            act = en & pd;
            chk("R10 pin sweep", {7'd0, irq_pin}, {7'd0, pol ? act : ~act});
        end
        rd_at(8'h02, b);
        chk("R9 status read clears pin", {7'd0, irq_pin}, {7'd0, 1'b0});

        // edge selectivity, polarity 0 enabled
        wr1(8'h01, 8'h49);
        rd_at(8'h02, b);
        chk("R9 cleared", {7'd0, irq_pin}, 8'd1);
        st_deadbat = 1'b1; settle();
        chk("R8 deadbat rise", {7'd0, irq_pin}, 8'd0);
        rd_at(8'h02, b);
        chk("R7 status with deadbat", b, {3'd5, st_vbus, 1'b1, 1'b0, 1'b1, 1'b0});
        chk("R9 clear after read", {7'd0, irq_pin}, 8'd1);
        st_deadbat = 1'b0; settle();
        chk("R8 deadbat fall ignored", {7'd0, irq_pin}, 8'd1);
        st_dcd = 1'b1; settle();
        chk("R8 dcd rise", {7'd0, irq_pin}, 8'd0);
        rd_at(8'h02, b);
        st_dcd = 1'b0; settle();
        chk("R8 dcd fall ignored", {7'd0, irq_pin}, 8'd1);
        st_vbus = ~st_vbus; settle();
        chk("R8 vbus change", {7'd0, irq_pin}, 8'd0);
        rd_at(8'h02, b);

        // masking keeps events latched
        wr1(8'h01, 8'h09);
        st_dcd = 1'b1; settle();
        chk("R10 masked pin inactive", {7'd0, irq_pin}, 8'd1);
        wr1(8'h01, 8'h49);
        chk("R10 unmask shows latched event", {7'd0, irq_pin}, 8'd0);
        rd_at(8'h02, b);
        chk("R9 final clear", {7'd0, irq_pin}, 8'd1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired R1 sequence stalled actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule